// File: doc/BRIEF.md
# Two-Dimensional Parity Codec

This block protects data held in blocks of eight 4-bit rows with a crossed parity code. An encoder path takes eight nibbles on a streaming input and emits eight 5-bit rows, each holding the nibble plus a row parity bit, followed by one extra check row that carries the column parities. A decoder path takes the nine rows of a block, recomputes every row and column parity, and releases the eight data nibbles together with a verdict for the block.

A single flipped bit anywhere in the 9×5 block shows up as exactly one failing row and exactly one failing column. If the crossing lies in the data area, that bit is inverted on the way out. If it lies on a check bit, the data is already correct and passes unchanged. Every other non-zero syndrome is only reported. Both paths use valid/ready handshakes with one row per beat. The decoder holds the whole block before it releases anything.

Top module: `grid_parity_codec`

## Requirements
- R1: Each encoder data row carries the nibble in bits 3..0 and, in bit 4, the XOR of those four bits. Bit 4 is therefore 1 when the nibble has an odd number of ones.
- R2: After every eighth data row, the encoder emits a check row. Bit c (c = 0..3) is the XOR of data bit c over the eight rows, and bit 4 is the XOR of the eight row parity bits. While this row is pending, `enc_in_ready` is low and `enc_out_valid` is high.
- R3: Data rows leave the encoder in arrival order with no added latency. During data rows, `enc_out_valid` follows `enc_in_valid` and `enc_in_ready` follows `enc_out_ready`. A stalled check row holds its value.
- R4: The decoder accepts exactly nine rows with `dec_in_ready` high and `dec_out_valid` low. It then drops `dec_in_ready` and presents eight output beats. It accepts the next block only after the eighth beat has been taken.
- R5: When the block arrives unchanged, the decoder outputs the original nibbles with both `dec_out_fixed` and `dec_out_bad` low.
- R6: When exactly one data bit is inverted, the decoder restores the original nibble and raises `dec_out_fixed`.
- R7: When exactly one check bit is inverted, the decoder outputs the original nibbles and raises `dec_out_fixed`. A check bit is a row parity bit of rows 0..7, or any bit of the check row.
- R8: Any other non-zero syndrome raises `dec_out_bad`, keeps `dec_out_fixed` low, and outputs the received nibbles unaltered. Examples are two flips in one row, two flips in one column, or flips in two rows and two columns.
- R9: The verdict flags stay the same on all eight beats of a block. While `dec_out_ready` is low, the output beat and its flags hold.
- R10: During reset and right after it, `enc_out_valid` and `dec_out_valid` are low (with no encoder input offered) and `dec_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_in_valid | input | 1 | Encoder input nibble valid |
| enc_in_ready | output | 1 | Encoder can take a nibble |
| enc_in_nib | input | COLS | Encoder input nibble |
| enc_out_valid | output | 1 | Encoder output row valid |
| enc_out_ready | input | 1 | Downstream takes an encoder row |
| enc_out_row | output | COLS+1 | Encoded row, bit COLS is the parity |
| dec_in_valid | input | 1 | Decoder input row valid |
| dec_in_ready | output | 1 | Decoder can take a row |
| dec_in_row | input | COLS+1 | Received row, data in low bits, parity on top |
| dec_out_valid | output | 1 | Decoder output nibble valid |
| dec_out_ready | input | 1 | Downstream takes a decoded nibble |
| dec_out_nib | output | COLS | Decoded (possibly corrected) nibble |
| dec_out_fixed | output | 1 | A single-bit error was found in this block |
| dec_out_bad | output | 1 | The syndrome cannot be corrected |

## Verification
The hardest case to reach is a single flip on a check bit. Such a flip makes the syndrome point at the parity column or at the check row instead of the data area, so ordinary data corruption never produces it. The stimulus therefore sweeps all 45 single-bit positions of the 9×5 block over freshly encoded random data. Each position is paired with the original nibbles as the expected output. Two-bit patterns in the same row, the same column and on a diagonal drive the uncorrectable branch. Both ready inputs are throttled at random, which keeps the stall and hold behaviour under pressure throughout.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  parameter int unsigned GP_ROWS = 8;
  parameter int unsigned GP_COLS = 4;

  typedef enum logic {EP_DATA, EP_CHECK} enc_phase_e;
  typedef enum logic {DP_FILL, DP_DRAIN} dec_phase_e;
endpackage

// File: rtl/gpc_encoder.sv
module gpc_encoder
  import gpc_pkg::*;
#(
  parameter int unsigned ROWS = GP_ROWS,
  parameter int unsigned COLS = GP_COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [COLS-1:0] in_nib,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [COLS:0]   out_row
);
  localparam int unsigned CW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ROWS - 1);

  enc_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [COLS:0] acc_q, acc_d;
  logic [COLS:0] data_row;
  logic          fire;

  always_comb begin
    data_row  = {^in_nib, in_nib};
    out_valid = (phase_q == EP_CHECK) ? 1'b1 : in_valid;
    out_row   = (phase_q == EP_CHECK) ? acc_q : data_row;
    in_ready  = (phase_q == EP_DATA) && out_ready;
    fire      = out_valid && out_ready;
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    if (phase_q == EP_DATA) begin
      acc_d = (cnt_q == '0) ? data_row : (acc_q ^ data_row);
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        phase_d = EP_CHECK;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      phase_d = EP_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= EP_DATA;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else if (fire) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
    end
  end
endmodule

// File: rtl/gpc_locate.sv
module gpc_locate
  import gpc_pkg::*;
#(
  parameter int unsigned ROWS = GP_ROWS,
  parameter int unsigned COLS = GP_COLS
) (
  input  logic [ROWS:0]   row_fail,
  input  logic [COLS:0]   col_fail,
  output logic [ROWS-1:0] hit_row,
  output logic [COLS-1:0] hit_col,
  output logic            fixed,
  output logic            bad
);
  logic clean, single;

  always_comb begin
    clean  = (row_fail == '0) && (col_fail == '0);
    single = ($countones(row_fail) == 1) && ($countones(col_fail) == 1);
    fixed  = single;
    bad    = !clean && !single;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign hit_row[r] = single && row_fail[r];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign hit_col[c] = single && col_fail[c];
  end
endmodule

// File: rtl/gpc_decoder.sv
module gpc_decoder
  import gpc_pkg::*;
#(
  parameter int unsigned ROWS = GP_ROWS,
  parameter int unsigned COLS = GP_COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [COLS:0]   in_row,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [COLS-1:0] out_nib,
  output logic            out_fixed,
  output logic            out_bad
);
  localparam int unsigned IW = $clog2(ROWS + 1);
  localparam int unsigned OW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [IW-1:0] ILAST = IW'(ROWS);
  localparam logic [OW-1:0] OLAST = OW'(ROWS - 1);

  dec_phase_e    phase_q, phase_d;
  logic [IW-1:0] icnt_q, icnt_d;
  logic [OW-1:0] ocnt_q, ocnt_d;
  logic [ROWS:0] rfail_q, rfail_d;
  logic [COLS:0] csyn_q, csyn_d;
  logic [COLS-1:0] store_q [ROWS];
  logic          take, give;
  logic [ROWS-1:0] hit_row;
  logic [COLS-1:0] hit_col;

  always_comb begin
    in_ready  = (phase_q == DP_FILL);
    out_valid = (phase_q == DP_DRAIN);
    take      = in_valid && in_ready;
    give      = out_valid && out_ready;
  end

  always_comb begin
    phase_d = phase_q;
    icnt_d  = icnt_q;
    ocnt_d  = ocnt_q;
    rfail_d = rfail_q;
    csyn_d  = csyn_q;
    if (take) begin
      rfail_d[icnt_q] = ^in_row;
      csyn_d          = (icnt_q == '0) ? in_row : (csyn_q ^ in_row);
      if (icnt_q == ILAST) begin
        icnt_d  = '0;
        phase_d = DP_DRAIN;
      end else begin
        icnt_d = icnt_q + 1'b1;
      end
    end
    if (give) begin
      if (ocnt_q == OLAST) begin
        ocnt_d  = '0;
        phase_d = DP_FILL;
      end else begin
        ocnt_d = ocnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= DP_FILL;
      icnt_q  <= '0;
      ocnt_q  <= '0;
      rfail_q <= '0;
      csyn_q  <= '0;
    end else if (take || give) begin
      phase_q <= phase_d;
      icnt_q  <= icnt_d;
      ocnt_q  <= ocnt_d;
      rfail_q <= rfail_d;
      csyn_q  <= csyn_d;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_store
    localparam logic [IW-1:0] RI = IW'(r);
    always_ff @(posedge clk) begin
      if (take && (icnt_q == RI)) store_q[r] <= in_row[COLS-1:0];
    end
  end

  gpc_locate #(.ROWS(ROWS), .COLS(COLS)) u_locate (
    .row_fail (rfail_q),
    .col_fail (csyn_q),
    .hit_row  (hit_row),
    .hit_col  (hit_col),
    .fixed    (out_fixed),
    .bad      (out_bad)
  );

  always_comb begin
    out_nib = store_q[ocnt_q] ^ (hit_row[ocnt_q] ? hit_col : '0);
  end
endmodule

// File: rtl/grid_parity_codec.sv
module grid_parity_codec
  import gpc_pkg::*;
#(
  parameter int unsigned ROWS = GP_ROWS,
  parameter int unsigned COLS = GP_COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enc_in_valid,
  output logic            enc_in_ready,
  input  logic [COLS-1:0] enc_in_nib,
  output logic            enc_out_valid,
  input  logic            enc_out_ready,
  output logic [COLS:0]   enc_out_row,
  input  logic            dec_in_valid,
  output logic            dec_in_ready,
  input  logic [COLS:0]   dec_in_row,
  output logic            dec_out_valid,
  input  logic            dec_out_ready,
  output logic [COLS-1:0] dec_out_nib,
  output logic            dec_out_fixed,
  output logic            dec_out_bad
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  gpc_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_nib    (enc_in_nib),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_row   (enc_out_row)
  );

  gpc_decoder #(.ROWS(ROWS), .COLS(COLS)) u_dec (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_row    (dec_in_row),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_nib   (dec_out_nib),
    .out_fixed (dec_out_fixed),
    .out_bad   (dec_out_bad)
  );
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker
  import gpc_pkg::*;
#(
  parameter int unsigned ROWS = GP_ROWS,
  parameter int unsigned COLS = GP_COLS
) (
  input logic            clk,
  input logic            rst_core_n,
  input logic            enc_in_ready,
  input logic            enc_out_valid,
  input logic            enc_out_ready,
  input logic [COLS:0]   enc_out_row,
  input logic            dec_in_valid,
  input logic            dec_in_ready,
  input logic            dec_out_valid,
  input logic            dec_out_ready,
  input logic [COLS-1:0] dec_out_nib,
  input logic            dec_out_fixed,
  input logic            dec_out_bad
);
  localparam int unsigned KW = $clog2(ROWS + 1);
  localparam logic [KW-1:0] KLAST = KW'(ROWS);

  logic [KW-1:0] enc_seen, dec_seen;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      enc_seen <= '0;
      dec_seen <= '0;
    end else begin
      if (enc_out_valid && enc_out_ready)
        enc_seen <= (enc_seen == KLAST) ? '0 : enc_seen + 1'b1;
      if (dec_in_valid && dec_in_ready)
        dec_seen <= (dec_seen == KLAST) ? '0 : dec_seen + 1'b1;
    end
  end

  a_r2_check_row_slot: assert property (@(posedge clk) disable iff (!rst_core_n)
    (enc_seen == KLAST) |-> (enc_out_valid && !enc_in_ready));

  a_r3_check_row_held: assert property (@(posedge clk) disable iff (!rst_core_n)
    (enc_seen == KLAST && !enc_out_ready) |=> $stable(enc_out_row));

  a_r4_drain_after_last_row: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_in_valid && dec_in_ready && dec_seen == KLAST) |=> (dec_out_valid && !dec_in_ready));

  a_r4_no_output_mid_fill: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_seen != '0) |-> !dec_out_valid);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_core_n)
    dec_out_valid |-> !(dec_out_fixed && dec_out_bad));

  a_r9_output_held: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dec_out_valid && !dec_out_ready) |=>
      (dec_out_valid && $stable(dec_out_nib) && $stable(dec_out_fixed) && $stable(dec_out_bad)));
endmodule

bind grid_parity_codec gpc_checker #(.ROWS(ROWS), .COLS(COLS)) u_gpc_chk (
  .clk           (clk),
  .rst_core_n    (rst_core_n),
  .enc_in_ready  (enc_in_ready),
  .enc_out_valid (enc_out_valid),
  .enc_out_ready (enc_out_ready),
  .enc_out_row   (enc_out_row),
  .dec_in_valid  (dec_in_valid),
  .dec_in_ready  (dec_in_ready),
  .dec_out_valid (dec_out_valid),
  .dec_out_ready (dec_out_ready),
  .dec_out_nib   (dec_out_nib),
  .dec_out_fixed (dec_out_fixed),
  .dec_out_bad   (dec_out_bad)
);

// File: tb/tb_grid_parity_codec.sv
module tb_grid_parity_codec;
  localparam int ROWS = 8;
  localparam int COLS = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic enc_in_valid, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [3:0] enc_in_nib;
  logic [4:0] enc_out_row;
  logic dec_in_valid, dec_in_ready, dec_out_valid, dec_out_ready;
  logic [4:0] dec_in_row;
  logic [3:0] dec_out_nib;
  logic dec_out_fixed, dec_out_bad;

  grid_parity_codec #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_nib(enc_in_nib),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_row(enc_out_row),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_row(dec_in_row),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_nib(dec_out_nib),
    .dec_out_fixed(dec_out_fixed), .dec_out_bad(dec_out_bad)
  );

  typedef struct {int nib; bit fx; bit bd; string req;} dexp_t;
  dexp_t dq[$];
  int    eq[$];
  int checks = 0, fails = 0;
  bit live = 0, finished = 0;
  int e_cnt = 0, e_acc = 0, d_in = 0, d_out = 0;

  function automatic int par(int v);
    int p = 0;
    for (int i = 0; i < 5; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // reference model, evaluated every clock away from the active edge
  always @(negedge clk) if (live) begin
    if (e_cnt == ROWS)
      chk(!enc_in_ready && enc_out_valid, "R2 check row blocks input",
          {enc_in_ready, enc_out_valid}, 1);
    else
      chk(enc_out_valid == enc_in_valid && enc_in_ready == enc_out_ready, "R3 pass-through handshake",
          {enc_out_valid, enc_in_ready}, {enc_in_valid, enc_out_ready});
    if (enc_out_valid && enc_out_ready) begin
      if (e_cnt < ROWS) begin
        int n; int ex;
        n  = (eq.size() != 0) ? eq.pop_front() : 0;
        ex = (par(n) << 4) | n;
        chk(enc_out_row == ex, "R1 data row", enc_out_row, ex);
        e_acc ^= ex;
        e_cnt++;
      end else begin
        chk(enc_out_row == e_acc, "R2 check row", enc_out_row, e_acc);
        e_cnt = 0;
        e_acc = 0;
      end
    end

    if (d_in == ROWS + 1)
      chk(!dec_in_ready && dec_out_valid, "R4 draining", {dec_in_ready, dec_out_valid}, 1);
    else
      chk(dec_in_ready && !dec_out_valid, "R4 filling", {dec_in_ready, dec_out_valid}, 2);
    if (dec_in_valid && dec_in_ready && d_in <= ROWS) d_in++;
    if (dec_out_valid && dec_out_ready) begin
      dexp_t e;
      if (dq.size() != 0) begin
        e = dq.pop_front();
        chk(dec_out_nib == e.nib, e.req, dec_out_nib, e.nib);
        chk(dec_out_fixed == e.fx && dec_out_bad == e.bd, {e.req, " R9 flags"},
            {dec_out_fixed, dec_out_bad}, {e.fx, e.bd});
      end else begin
        chk(0, "R4 unexpected output", dec_out_nib, 0);
      end
      d_out++;
      if (d_out == ROWS) begin
        d_out = 0;
        d_in  = 0;
      end
    end
  end

  initial begin
    enc_out_ready = 0;
    dec_out_ready = 0;
    forever begin
      @(posedge clk); #1;
      enc_out_ready = ($urandom % 4) != 0;
      dec_out_ready = ($urandom % 4) != 0;
    end
  end

  task automatic enc_send(int n);
    eq.push_back(n);
    enc_in_valid = 1;
    enc_in_nib   = 4'(n);
    forever begin
      @(negedge clk);
      if (enc_in_ready) break;
    end
    @(posedge clk); #1;
    enc_in_valid = 0;
    if ($urandom % 3 == 0) begin @(posedge clk); #1; end
  endtask

  task automatic dec_send(int row);
    dec_in_valid = 1;
    dec_in_row   = 5'(row);
    forever begin
      @(negedge clk);
      if (dec_in_ready) break;
    end
    @(posedge clk); #1;
    dec_in_valid = 0;
    if ($urandom % 4 == 0) begin @(posedge clk); #1; end
  endtask

  task automatic make_rows(input int d[8], output int rows[9]);
    int chkrow = 0;
    for (int r = 0; r < 8; r++) begin
      rows[r] = (par(d[r]) << 4) | d[r];
      chkrow ^= rows[r];
    end
    rows[8] = chkrow;
  endtask

  task automatic dec_block(input int rows[9], input int orig[8], bit fx, bit bd, string req, bit use_rx);
    for (int r = 0; r < 8; r++) begin
      dexp_t e;
      e.nib = use_rx ? (rows[r] & 15) : orig[r];
      e.fx  = fx;
      e.bd  = bd;
      e.req = req;
      dq.push_back(e);
    end
    for (int r = 0; r < 9; r++) dec_send(rows[r]);
  endtask

  task automatic enc_stream();
    for (int b = 0; b < 10; b++)
      for (int r = 0; r < 8; r++) begin
        int n;
        n = (b == 0) ? 0 : (b == 1) ? 15 : (b == 2) ? r : int'($urandom % 16);
        enc_send(n);
      end
  endtask

  task automatic dec_stream();
    int d[8];
    int rows[9];
    // R5: clean blocks
    for (int k = 0; k < 3; k++) begin
      for (int r = 0; r < 8; r++) d[r] = (k == 0) ? 0 : int'($urandom % 16);
      make_rows(d, rows);
      dec_block(rows, d, 0, 0, "R5 clean", 0);
    end
    // R6/R7: every single-bit position of the 9x5 block
    for (int p = 0; p < 45; p++) begin
      for (int r = 0; r < 8; r++) d[r] = int'($urandom % 16);
      make_rows(d, rows);
      rows[p / 5] ^= (1 << (p % 5));
      if ((p / 5) < 8 && (p % 5) < 4) dec_block(rows, d, 1, 0, "R6 data flip", 0);
      else                             dec_block(rows, d, 1, 0, "R7 check flip", 0);
    end
    // R8: multi-bit patterns
    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < 8; r++) d[r] = int'($urandom % 16);
      make_rows(d, rows);
      case (k)
        0: rows[2] ^= 5'b00101;
        1: begin rows[1] ^= 5'b00010; rows[6] ^= 5'b00010; end
        2: begin rows[0] ^= 5'b00001; rows[5] ^= 5'b01000; end
        default: rows[7] ^= 5'b10001;
      endcase
      dec_block(rows, d, 0, 1, "R8 uncorrectable", 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    rst_n = 0;
    enc_in_valid = 0; enc_in_nib = 0;
    dec_in_valid = 0; dec_in_row = 0;
    repeat (3) begin
      @(negedge clk);
      chk(!enc_out_valid && !dec_out_valid && dec_in_ready, "R10 reset state",
          {enc_out_valid, dec_out_valid, dec_in_ready}, 1);
    end
    @(posedge clk); #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!enc_out_valid && !dec_out_valid && dec_in_ready, "R10 after reset",
        {enc_out_valid, dec_out_valid, dec_in_ready}, 1);
    @(posedge clk); #1 live = 1;
    fork
      enc_stream();
      dec_stream();
    join
    while (dq.size() != 0 || eq.size() != 0 || e_cnt != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    report();
  end
endmodule